// File: doc/BRIEF.md
# DMA Descriptor Condition Evaluator

This unit sits beside the sequencer of a descriptor-driven DMA channel and decides, for the descriptor that has just finished its work, three things. It decides whether the channel must stall, whether an interrupt request is raised, and whether the channel follows the descriptor's dependent word as a branch target or moves on to the next descriptor in sequence. All three decisions come from the same masked comparison of the channel's device-status bits. Each decision compares against its own select register and applies its own 2-bit mode.

The sequencer presents the current command pointer, the dependent word, the three mode fields and the device status, and pulses `eval_strobe`. One cycle later the unit shows one of two results. The first is a stall, with `wait_hold` set and nothing else changed. The second is a resolved step: a one-cycle `adv_done`, an optional one-cycle `irq_pulse` for a sticky interrupt bit elsewhere, the branch-taken status and the next command pointer. Software loads the three select registers through a simple write port.

Top module: `desc_cond_eval`

## Requirements
- R1: Three select registers are written through `sel_wr_en`/`sel_wr_idx`/`sel_wr_data`. Index 0 is the interrupt select, 1 the branch select and 2 the wait select. A write with index 3 changes nothing. Data bits 19:16 are the mask, bits 3:0 are the compare value, and all other data bits are ignored. All fields reset to 0. A write made at the same edge as a strobe applies only to later strobes.
- R2: A condition is true when (`dev_status` AND mask) equals (compare value AND mask). With a zero mask it is always true.
- R3: Each mode field decides an action as follows: 2'b00 never, 2'b01 when the condition is true, 2'b10 when the condition is false, 2'b11 always.
- R4: The wait decision uses the wait select and `wait_mode`, and it is evaluated first. When it is true, the cycle after the strobe shows `wait_hold`=1 with `irq_pulse`=0 and `adv_done`=0, and `branch_taken` and `next_ptr` keep their previous values.
- R5: When the wait decision is false, the cycle after the strobe shows `wait_hold`=0 and `adv_done`=1 for exactly one cycle. In that cycle `irq_pulse` equals the interrupt decision (interrupt select, `irq_mode`), for exactly one cycle.
- R6: On a resolved step with a true branch decision (branch select, `br_mode`), `next_ptr` becomes `dep_word` with its low log2(DESC_BYTES) bits cleared and `branch_taken` is set.
- R7: On a resolved step with a false branch decision, `next_ptr` becomes `cur_ptr` + DESC_BYTES and `branch_taken` is cleared.
- R8: After reset all outputs are 0. Without a strobe, `wait_hold`, `branch_taken` and `next_ptr` hold their values and the pulses stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr_en | input | 1 | Select register write enable |
| sel_wr_idx | input | 2 | Select register index (0 irq, 1 branch, 2 wait) |
| sel_wr_data | input | 32 | Write data: mask in 19:16, compare value in 3:0 |
| eval_strobe | input | 1 | Evaluate the current descriptor |
| dev_status | input | STAT_W | Device status bits, sampled with the strobe |
| irq_mode | input | 2 | Interrupt mode of the current command |
| br_mode | input | 2 | Branch mode of the current command |
| wait_mode | input | 2 | Wait mode of the current command |
| cur_ptr | input | ADDR_W | Current command pointer |
| dep_word | input | ADDR_W | Dependent word of the current descriptor |
| irq_pulse | output | 1 | One-cycle interrupt request |
| adv_done | output | 1 | One-cycle marker of a resolved step |
| wait_hold | output | 1 | Descriptor is stalled in a wait |
| branch_taken | output | 1 | Branch-taken status bit |
| next_ptr | output | ADDR_W | Next command pointer |

## Verification
A corrupted mask or compare field shows up on the first evaluation whose status bits differ in that field, one cycle after the strobe. The symptom is a wrong `wait_hold`, `irq_pulse` or `next_ptr`. A stale or lost `branch_taken` appears in the cycle after the next resolved step, and a wait that wrongly lets actions through shows as an `adv_done` in a cycle that should be stalled. Random status and mode mixes are therefore checked one cycle after every strobe, and directed cases cover zero masks, the ignored index and writes that coincide with a strobe.

// File: rtl/desc_cond_eval.sv
module desc_cond_eval #(
  parameter int STAT_W     = 4,
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16,
  parameter int MASK_LSB   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr_en,
  input  logic [1:0]        sel_wr_idx,
  input  logic [31:0]       sel_wr_data,
  input  logic              eval_strobe,
  input  logic [STAT_W-1:0] dev_status,
  input  logic [1:0]        irq_mode,
  input  logic [1:0]        br_mode,
  input  logic [1:0]        wait_mode,
  input  logic [ADDR_W-1:0] cur_ptr,
  input  logic [ADDR_W-1:0] dep_word,
  output logic              irq_pulse,
  output logic              adv_done,
  output logic              wait_hold,
  output logic              branch_taken,
  output logic [ADDR_W-1:0] next_ptr
);
  localparam int NSEL  = 3;
  localparam int ALIGN = $clog2(DESC_BYTES);

  logic [STAT_W-1:0] msk [NSEL];
  logic [STAT_W-1:0] cmp [NSEL];
  logic [NSEL-1:0]   cond;

  genvar g;
  generate
    for (g = 0; g < NSEL; g++) begin : g_sel
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          msk[g] <= '0;
          cmp[g] <= '0;
        end else if (sel_wr_en && sel_wr_idx == 2'(g)) begin
          msk[g] <= sel_wr_data[MASK_LSB +: STAT_W];
          cmp[g] <= sel_wr_data[STAT_W-1:0];
        end
      end
      assign cond[g] = ((dev_status ^ cmp[g]) & msk[g]) == '0;
    end
  endgenerate

  function automatic logic decide(input logic [1:0] mode, input logic c);
    case (mode)
      2'b00:   decide = 1'b0;
      2'b01:   decide = c;
      2'b10:   decide = !c;
      default: decide = 1'b1;
    endcase
  endfunction

  logic irq_d, br_d, wait_d;
  logic [ADDR_W-1:0] seq_ptr, br_ptr;

  assign irq_d   = decide(irq_mode,  cond[0]);
  assign br_d    = decide(br_mode,   cond[1]);
  assign wait_d  = decide(wait_mode, cond[2]);
  assign seq_ptr = cur_ptr + ADDR_W'(DESC_BYTES);
  assign br_ptr  = {dep_word[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse    <= 1'b0;
      adv_done     <= 1'b0;
      wait_hold    <= 1'b0;
      branch_taken <= 1'b0;
      next_ptr     <= '0;
    end else begin
      irq_pulse <= 1'b0;
      adv_done  <= 1'b0;
      if (eval_strobe) begin
        wait_hold <= wait_d;
        if (!wait_d) begin
          irq_pulse    <= irq_d;
          adv_done     <= 1'b1;
          branch_taken <= br_d;
          next_ptr     <= br_d ? br_ptr : seq_ptr;
        end
      end
    end
  end
endmodule

// File: rtl/desc_cond_eval_chk.sv
module desc_cond_eval_chk #(
  parameter int STAT_W     = 4,
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eval_strobe,
  input logic [1:0]        irq_mode,
  input logic [1:0]        wait_mode,
  input logic [ADDR_W-1:0] cur_ptr,
  input logic              irq_pulse,
  input logic              adv_done,
  input logic              wait_hold,
  input logic              branch_taken,
  input logic [ADDR_W-1:0] next_ptr
);
  // R4
  wait_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_hold |-> (!irq_pulse && !adv_done));
  // R5
  irq_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_strobe |=> !irq_pulse && !adv_done);
  // R3
  irq_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_strobe && irq_mode == 2'b00) |=> !irq_pulse);
  // R3
  irq_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_strobe && irq_mode == 2'b11 && wait_mode == 2'b00) |=> irq_pulse);
  // R8
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_strobe |=> $stable(branch_taken) && $stable(next_ptr) && $stable(wait_hold));
  // R7
  seq_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_strobe && wait_mode == 2'b00) |=> (adv_done &&
      (branch_taken || next_ptr == $past(cur_ptr) + ADDR_W'(DESC_BYTES))));
endmodule

bind desc_cond_eval desc_cond_eval_chk #(
  .STAT_W(STAT_W), .ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .eval_strobe(eval_strobe), .irq_mode(irq_mode),
  .wait_mode(wait_mode), .cur_ptr(cur_ptr), .irq_pulse(irq_pulse),
  .adv_done(adv_done), .wait_hold(wait_hold), .branch_taken(branch_taken),
  .next_ptr(next_ptr)
);

// File: tb/desc_cond_eval_tb.sv
module desc_cond_eval_tb;
  logic clk = 0, rst_n = 0;
  logic sel_wr_en = 0;
  logic [1:0] sel_wr_idx = 0;
  logic [31:0] sel_wr_data = 0;
  logic eval_strobe = 0;
  logic [3:0] dev_status = 0;
  logic [1:0] irq_mode = 0, br_mode = 0, wait_mode = 0;
  logic [31:0] cur_ptr = 0, dep_word = 0;
  logic irq_pulse, adv_done, wait_hold, branch_taken;
  logic [31:0] next_ptr;

  int n_chk = 0, n_bad = 0;
  logic [3:0] m_msk [3];
  logic [3:0] m_cmp [3];
  logic e_bt = 0, e_wait = 0;
  logic [31:0] e_ptr = 0;

  always #5 clk = ~clk;

  desc_cond_eval u_dut (.*);

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic m_dec(logic [1:0] mode, logic c);
    case (mode)
      2'b00: return 1'b0;
      2'b01: return c;
      2'b10: return !c;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic m_cond(int i, logic [3:0] st);
    return (st & m_msk[i]) == (m_cmp[i] & m_msk[i]);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_sel(logic [1:0] idx, logic [31:0] d);
    @(negedge clk);
    sel_wr_en = 1; sel_wr_idx = idx; sel_wr_data = d;
    @(negedge clk);
    sel_wr_en = 0;
    if (idx != 2'd3) begin
      m_msk[idx] = d[19:16];
      m_cmp[idx] = d[3:0];
    end
  endtask

  task automatic eval(logic [3:0] st, logic [1:0] im, logic [1:0] bm, logic [1:0] wm,
                      logic [31:0] cp, logic [31:0] dw);
    logic w, ir, b;
    @(negedge clk);
    dev_status = st; irq_mode = im; br_mode = bm; wait_mode = wm;
    cur_ptr = cp; dep_word = dw; eval_strobe = 1;
    w  = m_dec(wm, m_cond(2, st));
    ir = m_dec(im, m_cond(0, st));
    b  = m_dec(bm, m_cond(1, st));
    @(negedge clk);
    eval_strobe = 0;
    e_wait = w;
    if (!w) begin
      e_bt = b;
      e_ptr = b ? {dw[31:4], 4'b0} : cp + 32'd16;
    end
    chk("R4 wait_hold", wait_hold, e_wait);
    chk("R5 adv_done", adv_done, !w);
    chk("R5 irq_pulse", irq_pulse, !w && ir);
    chk("R6/R7 branch_taken", branch_taken, e_bt);
    chk("R6/R7 next_ptr", next_ptr, e_ptr);
    @(negedge clk);
    chk("R5 irq_pulse one cycle", irq_pulse, 0);
    chk("R8 hold next_ptr", next_ptr, e_ptr);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin m_msk[i] = 0; m_cmp[i] = 0; end
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R8 reset irq", irq_pulse, 0);
    chk("R8 reset done", adv_done, 0);
    chk("R8 reset wait", wait_hold, 0);
    chk("R8 reset bt", branch_taken, 0);
    chk("R8 reset ptr", next_ptr, 0);
    rst_n = 1;

    // R2 zero masks: condition true
    eval(4'h5, 2'b01, 2'b01, 2'b00, 32'h100, 32'h2345);
    eval(4'h5, 2'b10, 2'b10, 2'b00, 32'h200, 32'h2345);
    // R4 wait always, then wait if-clear with zero mask
    eval(4'h0, 2'b11, 2'b11, 2'b11, 32'h300, 32'h9999);
    eval(4'h0, 2'b11, 2'b11, 2'b10, 32'h300, 32'h9999);
    // R1 fields: mask 1010, value 1000; junk bits ignored
    wr_sel(2'd1, 32'hFFFA_FFF8 & 32'h000A_0008 | 32'hF0F0_0070);
    eval(4'b1000, 2'b00, 2'b01, 2'b00, 32'h400, 32'hABCDEF);
    eval(4'b1010, 2'b00, 2'b01, 2'b00, 32'h410, 32'hABCDEF);
    eval(4'b1101, 2'b00, 2'b01, 2'b00, 32'h420, 32'hABCDEF);
    // R1 index 3 ignored
    wr_sel(2'd3, 32'h000F_000F);
    eval(4'b1101, 2'b00, 2'b01, 2'b00, 32'h430, 32'h1230);
    // R1 write coinciding with a strobe applies only later
    wr_sel(2'd0, 32'h0001_0001);
    @(negedge clk);
    sel_wr_en = 1; sel_wr_idx = 0; sel_wr_data = 32'h0001_0000;
    dev_status = 4'h1; irq_mode = 2'b01; br_mode = 0; wait_mode = 0;
    cur_ptr = 32'h500; eval_strobe = 1;
    @(negedge clk);
    sel_wr_en = 0; eval_strobe = 0;
    chk("R1 old select used", irq_pulse, 1);
    m_msk[0] = 4'h1; m_cmp[0] = 4'h0;
    e_bt = 0; e_ptr = 32'h510; e_wait = 0;
    eval(4'h1, 2'b01, 2'b00, 2'b00, 32'h510, 32'h0);

    for (int k = 0; k < 400; k++) begin
      if ($urandom % 4 == 0)
        wr_sel(2'($urandom), $urandom);
      eval(4'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), $urandom, $urandom);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule